// File: doc/BRIEF.md
# Queue-to-Channel Transmit Scheduler

The block decides which of many circular transmit queues is served next. Each queue has an 8-bit write index that the host loads as it adds entries and an 8-bit read index that the scheduler advances. Each queue is mapped onto one of a smaller set of prioritised DMA channels through a 4-bit selector. More than one queue may share a channel. A queue is eligible when its active bit is set, its two indices differ, its selector names an existing channel, and that channel's bit in the channel-enable mask is set.

Among the eligible queues, the winner comes from the highest-numbered channel that has any request. Queues that share a channel take turns in round-robin order. The choice is put out as a grant on a valid/ready stream that carries the queue number, the channel number and the read index being served. The grant is held steady until it is accepted. On acceptance the served queue's read index moves forward by one, modulo 256. One cycle later the block pulses that queue's event line, but only when the queue's interrupt-enable bit is set. After an acceptance the output register is empty for one cycle. The next grant is therefore chosen from read indices that are already up to date.

Top module: `txq_sched`

## Requirements
- R1: After reset `gnt_valid` and every `q_event` bit are 0, and every read index is 0. Each queue's first grant carries index 0.
- R2: A queue whose `q_active` bit is 0, or whose read index equals its write index, is never granted.
- R3: Queue q's channel is the value of `q_chan_sel[4q+3:4q]`. A queue whose selector is 8 or more is never granted. Once its selector is changed to a valid channel, the queue is granted on that channel.
- R4: A queue is never granted while bit c of `ch_enable` is 0 for its channel c. Its pending entries are granted once that bit is set.
- R5: When queues on several channels are eligible, the grant goes to the queue on the highest-numbered channel.
- R6: Queues on one channel are served round-robin. The search starts at the queue number just above the last queue served on that channel, wrapping past the top. After reset, the search starts at queue 0.
- R7: A grant reports the queue, the channel and the read index being served. Each accepted grant advances that queue's read index by one, wrapping from 255 to 0. Successive grants of one queue therefore carry consecutive indices.
- R8: A grant is accepted on a clock edge where `gnt_valid` and `gnt_ready` are both 1. While `gnt_valid` is 1 and `gnt_ready` is 0, the queue, channel and index outputs stay unchanged and nothing advances. In the cycle after an acceptance, `gnt_valid` is 0.
- R9: In the cycle after an acceptance of queue q, `q_event` equals one-hot bit q if `irq_enable[q]` is 1, and is all zero otherwise. In every other cycle `q_event` is zero.

Grant-stream back-pressure rule: the sink may hold `gnt_ready` low for any length of time. The block keeps the offered grant unchanged until it is accepted, even if the configuration changes in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_active | input | 16 | Per-queue active bit |
| q_chan_sel | input | 64 | 4-bit channel selector per queue; queue q at bits 4q+3:4q |
| ch_enable | input | 8 | Per-channel request enable |
| irq_enable | input | 16 | Per-queue event enable |
| wr_we | input | 1 | Write strobe for a queue's write index |
| wr_q | input | 4 | Queue whose write index is loaded |
| wr_val | input | 8 | New write index value |
| gnt_valid | output | 1 | Grant offered |
| gnt_ready | input | 1 | Sink accepts the grant |
| gnt_queue | output | 4 | Granted queue |
| gnt_chan | output | 3 | Channel of the granted queue |
| gnt_idx | output | 8 | Read index being served |
| q_event | output | 16 | One-cycle per-queue event after acceptance |

## Verification
A corrupted read index shows up directly in `gnt_idx` on that queue's next grant. It also shows up as a missing or extra grant once the queue's emptiness is judged wrongly. A wrong round-robin pointer reorders the grants within one channel as soon as two queues on that channel are pending. A wrong priority resolve shows up in the first grant after several channels become eligible together. The scoreboard compares every accepted grant against its expected order, so any of these faults is caught on the first grant it affects. A wrong event mask is seen one cycle after that acceptance.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned TXQ_NQ    = 16;
  localparam int unsigned TXQ_NCH   = 8;
  localparam int unsigned TXQ_IDX_W = 8;
  localparam int unsigned TXQ_SEL_W = 4;

  typedef enum logic [0:0] {
    OUT_EMPTY = 1'b0,
    OUT_FULL  = 1'b1
  } out_state_e;
endpackage

// File: rtl/txq_index_bank.sv
module txq_index_bank #(
  parameter int unsigned NQ    = 16,
  parameter int unsigned NCH   = 8,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned SEL_W = 4,
  localparam int unsigned QW   = $clog2(NQ),
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_we,
  input  logic [QW-1:0]       wr_q,
  input  logic [IDX_W-1:0]    wr_val,
  input  logic                adv,
  input  logic [QW-1:0]       adv_q,
  input  logic [NQ-1:0]       q_active,
  input  logic [NQ*SEL_W-1:0] q_chan_sel,
  input  logic [NCH-1:0]      ch_enable,
  output logic [NQ*IDX_W-1:0] rd_idx_flat,
  output logic [NQ-1:0]       elig
);
  logic [IDX_W-1:0] wr_idx [NQ];
  logic [IDX_W-1:0] rd_idx [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [SEL_W-1:0] sel;
    logic             in_range;
    logic             chan_on;

    assign sel      = q_chan_sel[q*SEL_W +: SEL_W];
    assign in_range = (int'(sel) < int'(NCH));
    assign chan_on  = in_range && ch_enable[sel[CH_W-1:0]];
    assign elig[q]  = q_active[q] && (rd_idx[q] != wr_idx[q]) && chan_on;
    assign rd_idx_flat[q*IDX_W +: IDX_W] = rd_idx[q];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wr_idx[q] <= '0;
        rd_idx[q] <= '0;
      end else begin
        if (wr_we && (int'(wr_q) == q)) wr_idx[q] <= wr_val;
        if (adv && (int'(adv_q) == q))  rd_idx[q] <= rd_idx[q] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txq_rr_pick.sv
module txq_rr_pick #(
  parameter int unsigned NQ = 16,
  localparam int unsigned QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] req,
  input  logic          upd,
  input  logic [QW-1:0] upd_q,
  output logic          any,
  output logic [QW-1:0] pick
);
  logic [QW-1:0] last_q;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int unsigned k = 1; k <= NQ; k++) begin
      int unsigned idx;
      idx = (int'(last_q) + k) % NQ;
      if (!any && req[idx]) begin
        any  = 1'b1;
        pick = QW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= QW'(NQ - 1);
    else if (upd) last_q <= upd_q;
  end
endmodule

// File: rtl/txq_chan_prio.sv
module txq_chan_prio #(
  parameter int unsigned NQ  = 16,
  parameter int unsigned NCH = 8,
  localparam int unsigned QW   = $clog2(NQ),
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]    ch_any,
  input  logic [NCH*QW-1:0] ch_pick,
  output logic              hit,
  output logic [CH_W-1:0]   win_chan,
  output logic [QW-1:0]     win_queue
);
  always_comb begin
    hit       = 1'b0;
    win_chan  = '0;
    win_queue = '0;
    for (int unsigned c = 0; c < NCH; c++) begin
      if (ch_any[c]) begin
        hit       = 1'b1;
        win_chan  = CH_W'(c);
        win_queue = ch_pick[c*QW +: QW];
      end
    end
  end
endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txq_pkg::*;
#(
  parameter int unsigned NQ    = TXQ_NQ,
  parameter int unsigned NCH   = TXQ_NCH,
  parameter int unsigned IDX_W = TXQ_IDX_W,
  parameter int unsigned SEL_W = TXQ_SEL_W,
  localparam int unsigned QW   = $clog2(NQ),
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NQ-1:0]       q_active,
  input  logic [NQ*SEL_W-1:0] q_chan_sel,
  input  logic [NCH-1:0]      ch_enable,
  input  logic [NQ-1:0]       irq_enable,
  input  logic                wr_we,
  input  logic [QW-1:0]       wr_q,
  input  logic [IDX_W-1:0]    wr_val,
  output logic                gnt_valid,
  input  logic                gnt_ready,
  output logic [QW-1:0]       gnt_queue,
  output logic [CH_W-1:0]     gnt_chan,
  output logic [IDX_W-1:0]    gnt_idx,
  output logic [NQ-1:0]       q_event
);
  logic [NQ*IDX_W-1:0] rd_idx_flat;
  logic [NQ-1:0]       elig;
  logic [NCH-1:0]      ch_any;
  logic [NCH*QW-1:0]   ch_pick;
  logic                hit;
  logic [CH_W-1:0]     win_chan;
  logic [QW-1:0]       win_queue;
  out_state_e          out_st;
  logic                accept;

  assign gnt_valid = (out_st == OUT_FULL);
  assign accept    = gnt_valid && gnt_ready;

  txq_index_bank #(.NQ(NQ), .NCH(NCH), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_we       (wr_we),
    .wr_q        (wr_q),
    .wr_val      (wr_val),
    .adv         (accept),
    .adv_q       (gnt_queue),
    .q_active    (q_active),
    .q_chan_sel  (q_chan_sel),
    .ch_enable   (ch_enable),
    .rd_idx_flat (rd_idx_flat),
    .elig        (elig)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NQ-1:0] req;
    for (genvar q = 0; q < NQ; q++) begin : g_req
      assign req[q] = elig[q] && (int'(q_chan_sel[q*SEL_W +: SEL_W]) == c);
    end
    txq_rr_pick #(.NQ(NQ)) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .upd   (accept && (int'(gnt_chan) == c)),
      .upd_q (gnt_queue),
      .any   (ch_any[c]),
      .pick  (ch_pick[c*QW +: QW])
    );
  end

  txq_chan_prio #(.NQ(NQ), .NCH(NCH)) u_prio (
    .ch_any    (ch_any),
    .ch_pick   (ch_pick),
    .hit       (hit),
    .win_chan  (win_chan),
    .win_queue (win_queue)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_st    <= OUT_EMPTY;
      gnt_queue <= '0;
      gnt_chan  <= '0;
      gnt_idx   <= '0;
      q_event   <= '0;
    end else begin
      q_event <= '0;
      if (accept) begin
        out_st  <= OUT_EMPTY;
        q_event <= irq_enable & (NQ'(1) << gnt_queue);
      end else if (!gnt_valid && hit) begin
        out_st    <= OUT_FULL;
        gnt_queue <= win_queue;
        gnt_chan  <= win_chan;
        gnt_idx   <= rd_idx_flat[win_queue*IDX_W +: IDX_W];
      end
    end
  end
endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk #(
  parameter int unsigned NQ    = 16,
  parameter int unsigned NCH   = 8,
  parameter int unsigned IDX_W = 8,
  localparam int unsigned QW   = $clog2(NQ),
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NQ-1:0]    q_active,
  input logic [NCH-1:0]   ch_enable,
  input logic             gnt_valid,
  input logic             gnt_ready,
  input logic [QW-1:0]    gnt_queue,
  input logic [CH_W-1:0]  gnt_chan,
  input logic [IDX_W-1:0] gnt_idx,
  input logic [NQ-1:0]    q_event
);
  logic [NCH-1:0] en_q;
  logic [NQ-1:0]  act_q;

  always_ff @(posedge clk) begin
    en_q  <= ch_enable;
    act_q <= q_active;
  end

  AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_queue) && $stable(gnt_chan) && $stable(gnt_idx)); // R8
  AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_ready |=> !gnt_valid); // R8
  AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> en_q[gnt_chan]); // R4
  AST_QUEUE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> act_q[gnt_queue]); // R2
  AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_event)); // R9
  AST_EVENT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (q_event != '0) |-> $past(gnt_valid && gnt_ready)); // R9
endmodule

bind txq_sched txq_sched_chk #(.NQ(NQ), .NCH(NCH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_txq_sched.sv
module tb_txq_sched;
  typedef struct {
    int    q;
    int    ch;
    int    idx;
    string req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] q_active = '0;
  logic [63:0] q_chan_sel = '0;
  logic [7:0]  ch_enable = 8'hDF;
  logic [15:0] irq_enable = 16'hAAAA;
  logic        wr_we = 1'b0;
  logic [3:0]  wr_q = '0;
  logic [7:0]  wr_val = '0;
  logic        gnt_valid;
  logic        gnt_ready = 1'b1;
  logic [3:0]  gnt_queue;
  logic [2:0]  gnt_chan;
  logic [7:0]  gnt_idx;
  logic [15:0] q_event;

  int checks = 0;
  int fails = 0;
  bit started = 1'b0;
  bit done = 1'b0;
  item_t sb[$];
  logic [7:0] exp_rd [16];
  logic [7:0] wrv [16];

  always #4 clk = ~clk;

  txq_sched dut (
    .clk(clk), .rst_n(rst_n), .q_active(q_active), .q_chan_sel(q_chan_sel),
    .ch_enable(ch_enable), .irq_enable(irq_enable), .wr_we(wr_we), .wr_q(wr_q),
    .wr_val(wr_val), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
    .gnt_queue(gnt_queue), .gnt_chan(gnt_chan), .gnt_idx(gnt_idx), .q_event(q_event)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic host_wr(int q, logic [7:0] v);
    tick();
    wr_we = 1'b1; wr_q = 4'(q); wr_val = v;
    tick();
    wr_we = 1'b0;
  endtask

  task automatic load(int q, int n);
    wrv[q] = wrv[q] + 8'(n);
    host_wr(q, wrv[q]);
  endtask

  task automatic expect_gnt(int q, int ch, string req);
    item_t it;
    it.q = q; it.ch = ch; it.idx = int'(exp_rd[q]); it.req = req;
    sb.push_back(it);
    exp_rd[q] = exp_rd[q] + 8'd1;
  endtask

  task automatic set_sel(int q, int v);
    q_chan_sel[q*4 +: 4] = 4'(v);
  endtask

  task automatic drain();
    while (sb.size() != 0) tick();
    repeat (4) tick();
  endtask

  task automatic no_grant(int cycles, string req, string what);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      tick();
      if (gnt_valid) seen = 1'b1;
    end
    chk(!seen, req, what, int'(seen), 0);
  endtask

  // Monitor: compares each accepted grant against the scoreboard, and the event lines.
  bit prev_acc = 1'b0;
  int prev_q = 0;
  always @(negedge clk) begin
    if (started && !done) begin
      logic [15:0] ev_exp;
      ev_exp = (prev_acc && irq_enable[prev_q]) ? (16'd1 << prev_q) : 16'd0;
      chk(q_event == ev_exp, "R9", "event lines", int'(q_event), int'(ev_exp));
      prev_acc = 1'b0;
      if (gnt_valid && gnt_ready) begin
        prev_acc = 1'b1;
        prev_q = int'(gnt_queue);
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected grant of queue", int'(gnt_queue), -1);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(int'(gnt_queue) == it.q, it.req, "grant queue", int'(gnt_queue), it.q);
          chk(int'(gnt_chan) == it.ch, it.req, "grant channel", int'(gnt_chan), it.ch);
          chk(int'(gnt_idx) == it.idx, "R7", "grant index", int'(gnt_idx), it.idx);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin exp_rd[i] = '0; wrv[i] = '0; end
    repeat (3) tick();
    chk(gnt_valid == 1'b0, "R1", "valid in reset", int'(gnt_valid), 0);
    rst_n = 1'b1;
    tick();
    started = 1'b1;
    chk(gnt_valid == 1'b0, "R1", "valid after reset", int'(gnt_valid), 0);
    chk(q_event == 16'd0, "R1", "events after reset", int'(q_event), 0);

    // Single queue, first index 0 (R1), consecutive indices (R7)
    set_sel(3, 1);
    load(3, 3);
    for (int i = 0; i < 3; i++) expect_gnt(3, 1, "R7");
    q_active[3] = 1'b1;
    drain();
    no_grant(8, "R2", "grant from empty queue");

    // Inactive queue holds back (R2)
    set_sel(8, 7);
    load(8, 1);
    no_grant(10, "R2", "grant from inactive queue");
    expect_gnt(8, 7, "R2");
    q_active[8] = 1'b1;
    drain();

    // Channel priority (R5)
    set_sel(0, 0); set_sel(5, 4); set_sel(9, 2);
    load(0, 2); load(5, 2); load(9, 1);
    expect_gnt(5, 4, "R5"); expect_gnt(5, 4, "R5");
    expect_gnt(9, 2, "R5");
    expect_gnt(0, 0, "R5"); expect_gnt(0, 0, "R5");
    q_active[0] = 1'b1; q_active[5] = 1'b1; q_active[9] = 1'b1;
    drain();

    // Round-robin within one channel (R6)
    set_sel(2, 3); set_sel(6, 3); set_sel(11, 3);
    load(2, 2); load(6, 2); load(11, 2);
    for (int r = 0; r < 2; r++) begin
      expect_gnt(2, 3, "R6"); expect_gnt(6, 3, "R6"); expect_gnt(11, 3, "R6");
    end
    q_active[2] = 1'b1; q_active[6] = 1'b1; q_active[11] = 1'b1;
    drain();

    // Channel enable mask (R4)
    set_sel(1, 5);
    q_active[1] = 1'b1;
    load(1, 2);
    no_grant(20, "R4", "grant on disabled channel");
    expect_gnt(1, 5, "R4"); expect_gnt(1, 5, "R4");
    ch_enable = 8'hFF;
    drain();

    // Out-of-range selector (R3)
    set_sel(4, 9);
    q_active[4] = 1'b1;
    load(4, 1);
    no_grant(20, "R3", "grant with selector 9");
    expect_gnt(4, 2, "R3");
    set_sel(4, 2);
    drain();

    // Back-pressure (R8)
    set_sel(10, 0);
    q_active[10] = 1'b1;
    gnt_ready = 1'b0;
    expect_gnt(10, 0, "R8"); expect_gnt(10, 0, "R8");
    load(10, 2);
    while (!gnt_valid) tick();
    begin
      logic [3:0] hq; logic [7:0] hi;
      hq = gnt_queue; hi = gnt_idx;
      repeat (6) tick();
      chk(gnt_valid == 1'b1, "R8", "valid held", int'(gnt_valid), 1);
      chk(gnt_queue == hq, "R8", "queue held", int'(gnt_queue), int'(hq));
      chk(gnt_idx == hi, "R8", "index held", int'(gnt_idx), int'(hi));
    end
    gnt_ready = 1'b1;
    tick();
    chk(gnt_valid == 1'b0, "R8", "gap after accept", int'(gnt_valid), 0);
    drain();

    // Index wrap 255 -> 0 (R7)
    set_sel(7, 6);
    load(7, 250);
    for (int i = 0; i < 250; i++) expect_gnt(7, 6, "R7");
    q_active[7] = 1'b1;
    drain();
    load(7, 10);
    for (int i = 0; i < 10; i++) expect_gnt(7, 6, "R7");
    drain();

    chk(sb.size() == 0, "R7", "grants outstanding", sb.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule